// File: doc/BRIEF.md
# Snoop Inquire Cycle Initiator

This block is system-side bus logic that runs one cache inquire (snoop) cycle against a processor that holds a write-back cache. A requester hands it a cache-line address, an invalidate flag and one of three ways to take the processor's address bus: address hold, back-off, or hold with hold-acknowledge. The block raises the chosen bus-acquisition signal and waits for the bus. It then pulses an external-address strobe while it drives the line address and the invalidate flag, and samples the processor's hit, hit-modified and address-parity-check responses.

A miss or a clean hit ends the cycle at once. A hit on a modified line releases the acquisition signal so that the processor can run its four-beat burst write-back. The block then counts burst-ready pulses and reports completion only after the last one. When the processor reports bad address parity, the block discards the result and repeats the same inquire. The number of repeats is limited by a parameter. One more parity error after that limit ends the request with an abort status and raises a sticky error flag.

Top module: `snp_inquire_init`

## Requirements
- R1: While reset is active and after it is released, `req_ready` is 1 and `done_valid`, `retry_err`, all three acquisition outputs, `bus_eads`, `bus_inv` and `bus_addr` are 0.
- R2: `req_method` code 0 or 3 selects address hold (`bus_ahold`) and code 1 selects back-off (`bus_boff`). The selected signal rises in the cycle after the request is accepted, and `bus_eads` is high exactly two cycles after that signal first goes high.
- R3: `req_method` code 2 raises `bus_hold` in the cycle after acceptance. `bus_eads` goes high one cycle after the first clock edge that samples `bus_hlda` high. `bus_hlda` has no effect under the other methods.
- R4: `bus_eads` is a single-cycle pulse and is high only while an acquisition output is high. `bus_addr` carries the accepted line address and `bus_inv` the accepted invalidate flag only during that pulse. Both are 0 at all other times.
- R5: The hit, hit-modified and parity inputs are sampled at the end of the second cycle after the strobe cycle. With no parity error and no hit-modified, the next cycle is idle, with `done_valid`=1 and `done_status` 0 (miss) or 1 (hit without hit-modified). The acquisition signal is dropped in that same cycle.
- R6: A sampled hit-modified without a parity error drops the acquisition signal in the next cycle. From there no strobe is issued and no request is accepted until the fourth `bus_brdy` pulse is sampled. In the cycle after that pulse, `done_valid`=1 with `done_status` 2.
- R7: A sampled parity error ignores hit and hit-modified. While the retry count is below `MAX_RETRY`, the acquisition signal stays high and a new strobe for the same address and invalidate flag follows two cycles after the sampling cycle.
- R8: A parity error after `MAX_RETRY` retries ends the request with `done_valid`=1 and `done_status` 3, and sets `retry_err`. `retry_err` stays 1 until the next request is accepted. `MAX_RETRY` retries followed by a clean sample complete normally.
- R9: A request is accepted when `req_valid` and `req_ready` are both 1, and `req_ready` is 1 only when the block is idle. `done_valid` is a one-cycle pulse.
- R10: `bus_brdy` pulses while no write-back is in progress have no effect. A later write-back still needs four pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Snoop request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_line | input | ADDR_W-LINE_LSB | Cache-line address (address bits above the line offset) |
| req_inv | input | 1 | Invalidate flag for the inquire |
| req_method | input | 2 | Acquisition method: 0/3 address hold, 1 back-off, 2 hold |
| done_valid | output | 1 | Completion pulse |
| done_status | output | 2 | 0 miss, 1 clean hit, 2 dirty hit written back, 3 parity abort |
| retry_err | output | 1 | Sticky: parity retry limit exceeded |
| bus_ahold | output | 1 | Address-hold request to the processor |
| bus_boff | output | 1 | Back-off request to the processor |
| bus_hold | output | 1 | Bus hold request to the processor |
| bus_hlda | input | 1 | Hold acknowledge from the processor |
| bus_eads | output | 1 | External-address strobe |
| bus_addr | output | ADDR_W-LINE_LSB | Inquire line address, driven during the strobe |
| bus_inv | output | 1 | Invalidate, driven during the strobe |
| bus_hit | input | 1 | Processor reports a cache hit |
| bus_hitm | input | 1 | Processor reports a hit on a modified line |
| bus_apchk | input | 1 | Processor reports an address parity error |
| bus_brdy | input | 1 | Burst ready for a write-back beat |

## Verification
The bench checks strobe placement for each acquisition method. A design that counted from acceptance instead of from the rising acquisition signal, or from hold-acknowledge, would strobe one cycle off or strobe before the bus is granted. It sends parity errors up to the retry limit and one beyond it. A design off by one on the limit would abort a request that should succeed, or retry forever. Write-backs run with gaps between burst-ready pulses and after stray pulses in idle, which exposes a beat counter that finishes early or keeps stale counts. Hit inputs held high during a parity error would also reveal a design that trusts the corrupted result.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [1:0] {
        M_AHOLD = 2'd0,
        M_BOFF  = 2'd1,
        M_HOLD  = 2'd2
    } snp_method_e;

    localparam int unsigned SNP_NUM_METHODS = 3;

    typedef enum logic [1:0] {
        ST_MISS     = 2'd0,
        ST_CLEAN    = 2'd1,
        ST_DIRTY    = 2'd2,
        ST_PARABORT = 2'd3
    } snp_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETTLE,
        S_WAITACK,
        S_PRE,
        S_STROBE,
        S_SNP1,
        S_SNP2,
        S_WB
    } snp_state_e;

    typedef struct packed {
        snp_method_e meth;
        logic        inv;
    } snp_ctl_t;

    function automatic snp_method_e snp_norm_method(input logic [1:0] code);
        case (code)
            2'd1:    return M_BOFF;
            2'd2:    return M_HOLD;
            default: return M_AHOLD;
        endcase
    endfunction

    function automatic logic snp_bus_owned(input snp_state_e s);
        return (s == S_SETTLE) || (s == S_WAITACK) || (s == S_PRE) ||
               (s == S_STROBE) || (s == S_SNP1)    || (s == S_SNP2);
    endfunction

endpackage

// File: rtl/snp_acq_drv.sv
module snp_acq_drv
    import snp_pkg::*;
(
    input  logic        active,
    input  snp_method_e meth,
    output logic [SNP_NUM_METHODS-1:0] acq
);
    for (genvar g = 0; g < SNP_NUM_METHODS; g++) begin : g_acq
        assign acq[g] = active && (meth == snp_method_e'(2'(g)));
    end
endmodule

// File: rtl/snp_beat_cnt.sv
module snp_beat_cnt #(
    parameter int unsigned BEATS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic beat,
    output logic last
);
    localparam int unsigned CW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CW-1:0] FINAL = CW'(BEATS - 1);

    logic [CW-1:0] cnt_q;

    assign last = en && beat && (cnt_q == FINAL);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (beat) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/snp_retry_cnt.sv
module snp_retry_cnt #(
    parameter int unsigned MAX_RETRY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int unsigned CW = $clog2(MAX_RETRY + 2);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRY);

    logic [CW-1:0] cnt_q;

    assign exhausted = (cnt_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && !exhausted) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/snp_inquire_init.sv
module snp_inquire_init
    import snp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LINE_LSB  = 5,
    parameter int unsigned BEATS     = 4,
    parameter int unsigned MAX_RETRY = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-LINE_LSB-1:0] req_line,
    input  logic                       req_inv,
    input  logic [1:0]                 req_method,
    output logic                       done_valid,
    output logic [1:0]                 done_status,
    output logic                       retry_err,
    output logic                       bus_ahold,
    output logic                       bus_boff,
    output logic                       bus_hold,
    input  logic                       bus_hlda,
    output logic                       bus_eads,
    output logic [ADDR_W-LINE_LSB-1:0] bus_addr,
    output logic                       bus_inv,
    input  logic                       bus_hit,
    input  logic                       bus_hitm,
    input  logic                       bus_apchk,
    input  logic                       bus_brdy
);
    localparam int unsigned LW = ADDR_W - LINE_LSB;

    snp_state_e  state_q;
    snp_ctl_t    ctl_q;
    logic [LW-1:0] line_q;
    logic        done_q;
    snp_status_e status_q;
    logic        err_q;

    logic        accept;
    logic        par_seen;
    logic        retry_done;
    logic        wb_last;
    logic [SNP_NUM_METHODS-1:0] acq;

    assign accept   = (state_q == S_IDLE) && req_valid;
    assign par_seen = (state_q == S_SNP2) && bus_apchk;

    snp_retry_cnt #(.MAX_RETRY(MAX_RETRY)) retry_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .inc       (par_seen),
        .exhausted (retry_done)
    );

    snp_beat_cnt #(.BEATS(BEATS)) beat_i (
        .clk  (clk),
        .rst  (rst),
        .en   (state_q == S_WB),
        .beat (bus_brdy),
        .last (wb_last)
    );

    snp_acq_drv acq_i (
        .active (snp_bus_owned(state_q)),
        .meth   (ctl_q.meth),
        .acq    (acq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            ctl_q    <= '0;
            line_q   <= '0;
            done_q   <= 1'b0;
            status_q <= ST_MISS;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        line_q     <= req_line;
                        ctl_q.meth <= snp_norm_method(req_method);
                        ctl_q.inv  <= req_inv;
                        err_q      <= 1'b0;
                        state_q    <= (snp_norm_method(req_method) == M_HOLD)
                                      ? S_WAITACK : S_SETTLE;
                    end
                end
                S_SETTLE:  state_q <= S_PRE;
                S_WAITACK: if (bus_hlda) state_q <= S_PRE;
                S_PRE:     state_q <= S_STROBE;
                S_STROBE:  state_q <= S_SNP1;
                S_SNP1:    state_q <= S_SNP2;
                S_SNP2: begin
                    if (bus_apchk) begin
                        if (retry_done) begin
                            state_q  <= S_IDLE;
                            done_q   <= 1'b1;
                            status_q <= ST_PARABORT;
                            err_q    <= 1'b1;
                        end else begin
                            state_q <= S_PRE;
                        end
                    end else if (bus_hitm) begin
                        state_q <= S_WB;
                    end else begin
                        state_q  <= S_IDLE;
                        done_q   <= 1'b1;
                        status_q <= bus_hit ? ST_CLEAN : ST_MISS;
                    end
                end
                S_WB: begin
                    if (wb_last) begin
                        state_q  <= S_IDLE;
                        done_q   <= 1'b1;
                        status_q <= ST_DIRTY;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign req_ready   = (state_q == S_IDLE);
    assign done_valid  = done_q;
    assign done_status = status_q;
    assign retry_err   = err_q;

    assign bus_ahold = acq[M_AHOLD];
    assign bus_boff  = acq[M_BOFF];
    assign bus_hold  = acq[M_HOLD];

    assign bus_eads = (state_q == S_STROBE);
    assign bus_addr = bus_eads ? line_q : '0;
    assign bus_inv  = bus_eads && ctl_q.inv;

endmodule

// File: rtl/snp_inquire_chk.sv
module snp_inquire_chk #(
    parameter int unsigned LW = 27
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          done_valid,
    input logic [1:0]    done_status,
    input logic          retry_err,
    input logic          bus_ahold,
    input logic          bus_boff,
    input logic          bus_hold,
    input logic          bus_eads,
    input logic [LW-1:0] bus_addr,
    input logic          bus_inv
);
    // R2
    acq_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_ahold, bus_boff, bus_hold}));

    // R2
    ahold_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ahold) |-> ##2 bus_eads);

    // R2
    boff_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_boff) |-> ##2 bus_eads);

    // R4
    eads_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_eads |=> !bus_eads);

    // R4
    eads_owned_chk: assert property (@(posedge clk) disable iff (rst)
        bus_eads |-> (bus_ahold || bus_boff || bus_hold));

    // R4
    addr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_eads |-> (bus_addr == '0) && !bus_inv);

    // R9
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_ahold || bus_boff || bus_hold) |-> !req_ready);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    // R8
    err_status_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(retry_err) |-> done_valid && (done_status == 2'd3));
endmodule

bind snp_inquire_init snp_inquire_chk #(.LW(ADDR_W - LINE_LSB)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .done_valid  (done_valid),
    .done_status (done_status),
    .retry_err   (retry_err),
    .bus_ahold   (bus_ahold),
    .bus_boff    (bus_boff),
    .bus_hold    (bus_hold),
    .bus_eads    (bus_eads),
    .bus_addr    (bus_addr),
    .bus_inv     (bus_inv)
);

// File: tb/snp_inquire_init_tb.sv
module snp_inquire_init_tb_top;
    localparam int MAXR = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [26:0] req_line = '0;
    logic        req_inv = 1'b0;
    logic [1:0]  req_method = 2'd0;
    logic        hlda = 1'b0, hit = 1'b0, hitm = 1'b0, apchk = 1'b0, brdy = 1'b0;
    logic        req_ready, done_valid, retry_err;
    logic [1:0]  done_status;
    logic        ahold, boff, hold, eads, binv;
    logic [26:0] baddr;

    int total = 0;
    int bad   = 0;
    bit exp_err = 1'b0;

    always #5 clk = ~clk;

    snp_inquire_init #(.MAX_RETRY(MAXR)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_line(req_line), .req_inv(req_inv), .req_method(req_method),
        .done_valid(done_valid), .done_status(done_status), .retry_err(retry_err),
        .bus_ahold(ahold), .bus_boff(boff), .bus_hold(hold), .bus_hlda(hlda),
        .bus_eads(eads), .bus_addr(baddr), .bus_inv(binv),
        .bus_hit(hit), .bus_hitm(hitm), .bus_apchk(apchk), .bus_brdy(brdy)
    );

    // compare all outputs against the model's expectation for this cycle
    task automatic chk(input string r, input bit rdy, input logic [2:0] acq,
                       input bit e, input logic [26:0] ad, input bit iv,
                       input bit dn, input logic [1:0] sts);
        logic [34:0] got, exp;
        got = {req_ready, ahold, boff, hold, eads, baddr, binv, done_valid, retry_err};
        exp = {rdy, acq, e, ad, iv, dn, exp_err};
        total++;
        if (got !== exp || (dn && done_status !== sts)) begin
            bad++;
            $display("FAIL %s t=%0t got=%h/%0d exp=%h/%0d", r, $time,
                     got, done_status, exp, sts);
        end
    endtask

    task automatic idle_chk(input string r, input bit dn, input logic [1:0] sts);
        chk(r, 1'b1, 3'b000, 1'b0, '0, 1'b0, dn, sts);
    endtask

    task automatic snoop(input int meth, input bit iv, input logic [26:0] line,
                         input bit hit_r, input bit hitm_r, input int npar,
                         input int ack_dly, input int gap, input bit noise,
                         input string r);
        logic [2:0] a;
        a = (meth == 1) ? 3'b010 : (meth == 2) ? 3'b001 : 3'b100;
        @(negedge clk);
        idle_chk({r, " R9 idle before request"}, 1'b0, 2'd0);
        req_valid = 1'b1; req_line = line; req_inv = iv; req_method = 2'(meth);
        @(negedge clk);
        exp_err = 1'b0;
        chk({r, " R2/R3 acquisition raised"}, 1'b0, a, 1'b0, '0, 1'b0, 1'b0, 2'd0);
        req_valid = 1'b0; req_line = '1; req_inv = ~iv;
        if (meth == 2) begin
            if (ack_dly == 0) hlda = 1'b1;
            for (int i = 1; i <= ack_dly; i++) begin
                @(negedge clk);
                chk({r, " R3 waiting for hlda"}, 1'b0, a, 1'b0, '0, 1'b0, 1'b0, 2'd0);
                if (i == ack_dly) hlda = 1'b1;
            end
        end else if (noise) begin
            hlda = 1'b1; // R3: ignored under address hold / back-off
        end
        @(negedge clk);
        chk({r, " R2/R3 gap before strobe"}, 1'b0, a, 1'b0, '0, 1'b0, 1'b0, 2'd0);
        for (int at = 0; at <= MAXR + 1; at++) begin
            @(negedge clk);
            chk({r, " R4 strobe with line and inv"}, 1'b0, a, 1'b1, line, iv, 1'b0, 2'd0);
            @(negedge clk);
            chk({r, " R4 strobe dropped"}, 1'b0, a, 1'b0, '0, 1'b0, 1'b0, 2'd0);
            @(negedge clk);
            chk({r, " R5 response wait"}, 1'b0, a, 1'b0, '0, 1'b0, 1'b0, 2'd0);
            hit = hit_r; hitm = hitm_r; apchk = (at < npar);
            @(negedge clk);
            hit = 1'b0; hitm = 1'b0;
            if (apchk) begin
                apchk = 1'b0;
                if (at < MAXR) begin
                    chk({r, " R7 retry keeps bus"}, 1'b0, a, 1'b0, '0, 1'b0, 1'b0, 2'd0);
                    continue;
                end
                exp_err = 1'b1;
                idle_chk({r, " R8 parity abort"}, 1'b1, 2'd3);
            end else if (hitm_r) begin
                chk({r, " R6 bus released for write-back"}, 1'b0, 3'b000, 1'b0, '0, 1'b0, 1'b0, 2'd0);
                hlda = 1'b0;
                for (int b = 0; b < 4; b++) begin
                    for (int g = 0; g < gap; g++) begin
                        @(negedge clk);
                        chk({r, " R6 write-back gap"}, 1'b0, 3'b000, 1'b0, '0, 1'b0, 1'b0, 2'd0);
                    end
                    brdy = 1'b1;
                    @(negedge clk);
                    brdy = 1'b0;
                    if (b < 3)
                        chk({r, " R6 write-back beat"}, 1'b0, 3'b000, 1'b0, '0, 1'b0, 1'b0, 2'd0);
                    else
                        idle_chk({r, " R6 dirty done after last beat"}, 1'b1, 2'd2);
                end
            end else begin
                idle_chk({r, " R5 done miss/clean"}, 1'b1, hit_r ? 2'd1 : 2'd0);
            end
            break;
        end
        hlda = 1'b0;
        @(negedge clk);
        idle_chk({r, " R9 done pulse ends"}, 1'b0, 2'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        idle_chk("R1 during reset", 1'b0, 2'd0);
        rst = 1'b0;
        @(negedge clk);
        idle_chk("R1 after reset", 1'b0, 2'd0);

        snoop(0, 1'b0, 27'h0ABCDEF, 1'b0, 1'b0, 0, 0, 0, 1'b0, "R2 ahold miss");
        snoop(1, 1'b1, 27'h5555AAA, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R2 boff clean hit");
        snoop(2, 1'b0, 27'h7FFFFFF, 1'b0, 1'b0, 0, 3, 0, 1'b0, "R3 hold late ack miss");
        snoop(2, 1'b1, 27'h0000001, 1'b1, 1'b1, 0, 0, 1, 1'b0, "R3 R6 hold dirty");
        snoop(0, 1'b1, 27'h1234567, 1'b1, 1'b1, 0, 0, 0, 1'b1, "R6 R3 ahold dirty with hlda noise");
        snoop(3, 1'b1, 27'h2468ACE, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R2 code3 as ahold");
        snoop(1, 1'b0, 27'h3C3C3C3, 1'b1, 1'b0, 1, 0, 0, 1'b0, "R7 boff one retry");
        snoop(0, 1'b1, 27'h6000001, 1'b1, 1'b1, 3, 0, 0, 1'b0, "R8 ahold retry cap exceeded");
        // R8: err stays set while idle, cleared by the next accepted request
        @(negedge clk);
        idle_chk("R8 err sticky in idle", 1'b0, 2'd0);
        // R10: stray burst-ready pulses while idle
        brdy = 1'b1;
        repeat (3) begin
            @(negedge clk);
            idle_chk("R10 idle brdy ignored", 1'b0, 2'd0);
        end
        brdy = 1'b0;
        snoop(1, 1'b0, 27'h0F0F0F0, 1'b0, 1'b1, 0, 0, 2, 1'b0, "R10 R8 boff dirty after stray brdy");
        snoop(2, 1'b1, 27'h4444444, 1'b0, 1'b1, MAXR, 1, 0, 1'b0, "R7 R8 hold retries at cap then dirty");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule